// File: doc/BRIEF.md
# Watchdog Timer with Keyed Restart

This block is a memory-mapped watchdog. A 32-bit down-counter runs while the enable bit of the control register is set. Software must write a fixed key to the restart register before the count runs out. If it does not, the block raises a one-cycle timeout event and then reloads itself. That event can request a reset of a chosen scope, raise an interrupt, trigger an external pulse generator, and latch an alternate-boot flag. The flag stays set until software clears it through a dedicated clear register.

The counter either steps once per system clock, or once per prescaled tick. The prescaled tick comes from dividing the system clock by the parameter `TICK_DIV`, nominally to 1 MHz.

A small state machine sequences the counter:
- `ST_OFF` holds the count frozen.
- `ST_OFF -> ST_RUN` (enable seen) loads the reload value.
- `ST_RUN -> ST_RUN` decrements on each tick, or reloads on a valid restart.
- `ST_RUN -> ST_FIRE` (tick while the count is zero) reloads and marks the timeout cycle.
- `ST_FIRE -> ST_RUN` continues counting.
- `ST_RUN/ST_FIRE -> ST_OFF` happens when the enable bit is cleared.

Top module: `wdog_timer`

## Requirements
- R1: After reset the count reads 0x00FFFFFF. The reload, control and status registers read 0, and all timeout outputs are low.
- R2: Byte offsets are decoded as follows. 0x00 returns the count (read only). 0x04 is the reload value (read/write). 0x0C is control, with bits 7:0 read/write and upper bits reading 0. 0x10 returns status in bits 1:0. Reads of the restart register (0x08) and the clear register (0x14) return 0.
- R3: A write of exactly 0x00004755 to offset 0x08 copies the reload value into the counter at that edge, in any state. Any other value written there leaves the count untouched.
- R4: Control bit 0 enables counting. Its rise loads the reload value. While it is clear, the count is frozen.
- R5: With control bit 4 clear, the count steps down once per clock. A tick at count 0 is the timeout: the counter reloads, so timeouts repeat every reload+1 cycles. The first timeout is visible reload+2 cycles after the enabling write edge.
- R6: With control bit 4 set, the count steps once every `TICK_DIV` clocks. The divider restarts when counting starts, so timeouts repeat every (reload+1)*`TICK_DIV` cycles.
- R7: Each timeout drives its outputs high for exactly the one cycle after the timeout edge. `irq` follows control bit 2, `ext_trig` follows control bit 3 and `rst_req` follows control bit 1. A disabled output stays low.
- R8: `rst_scope` presents control bits 6:5. The code 0 resets the SoC, 1 the full chip and 2 only the CPU.
- R9: Status bit 0 is set by every timeout. Status bit 1 is set by a timeout while control bit 7 is set. Both are sticky, and `alt_boot` mirrors bit 1.
- R10: A write to offset 0x14 with bit 0 set clears both status bits. A write there with bit 0 clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the same cycle as a read strobe |
| rst_req | output | 1 | One-cycle reset request on timeout |
| rst_scope | output | 2 | Reset scope code from control bits 6:5 |
| irq | output | 1 | One-cycle timeout interrupt |
| ext_trig | output | 1 | One-cycle trigger for the external pulse shaper |
| alt_boot | output | 1 | Sticky alternate-boot select flag |

## Verification
The hardest case to show from the ports is that a wrong restart key has no effect while the counter is running. A wrong key and a correct one both leave every output quiet at the moment of the write, so neither can be seen directly.

The stimulus therefore issues the bad key partway through a period and relies on the scoreboard. The scoreboard expects the next timeout on the unchanged schedule. A real key is then written at a known edge, and the expected timeout moves by a known number of cycles.

While the timer is disabled, the same key check is also seen directly in the count read back through offset 0x00. The slow-tick mode is timed from the enabling edge, which pins down the divider phase.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam logic [4:0] OFS_COUNT  = 5'h00;
    localparam logic [4:0] OFS_RELOAD = 5'h04;
    localparam logic [4:0] OFS_KICK   = 5'h08;
    localparam logic [4:0] OFS_CTRL   = 5'h0C;
    localparam logic [4:0] OFS_STAT   = 5'h10;
    localparam logic [4:0] OFS_CLR    = 5'h14;

    localparam logic [31:0] KICK_KEY  = 32'h0000_4755;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2
    } wd_state_e;

    typedef enum logic [1:0] {
        SCOPE_SOC  = 2'd0,
        SCOPE_CHIP = 2'd1,
        SCOPE_CPU  = 2'd2,
        SCOPE_RSVD = 2'd3
    } scope_e;

    // control word, bit 7 down to bit 0
    typedef struct packed {
        logic       alt_boot;
        logic [1:0] scope;
        logic       slow_tick;
        logic       ext_en;
        logic       irq_en;
        logic       rst_en;
        logic       run_en;
    } ctrl_t;

endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int unsigned DIV = 125
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic tick_o
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV > 1) begin : g_div
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni)
                    cnt_q <= '0;
                else if (!run_i || cnt_q == CW'(DIV - 1))
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_q + 1'b1;
            end

            assign tick_o = run_i && (cnt_q == CW'(DIV - 1));

            // R6: divided ticks never come back to back
            p_tick_spacing_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
                tick_o |=> !tick_o);
        end else begin : g_pass
            assign tick_o = run_i;
        end
    endgenerate

endmodule

// File: rtl/wdog_count.sv
module wdog_count
    import wdog_pkg::*;
#(
    parameter int unsigned      CNT_W   = 32,
    parameter logic [CNT_W-1:0] PRELOAD = 'h00FF_FFFF
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_en_i,
    input  logic             rst_en_i,
    input  logic             irq_en_i,
    input  logic             ext_en_i,
    input  logic             tick_i,
    input  logic             kick_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             active_o,
    output logic             fire_o,
    output logic             rst_req_o,
    output logic             irq_o,
    output logic             ext_trig_o
);
    wd_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next-state and count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_OFF: begin
                if (run_en_i) begin
                    state_d = ST_RUN;
                    cnt_d   = reload_i;
                end else if (kick_i) begin
                    cnt_d   = reload_i;
                end
            end
            ST_RUN, ST_FIRE: begin
                if (!run_en_i) begin
                    state_d = ST_OFF;
                    if (kick_i) cnt_d = reload_i;
                end else if (kick_i) begin
                    state_d = ST_RUN;
                    cnt_d   = reload_i;
                end else if (tick_i && cnt_q == '0) begin
                    state_d = ST_FIRE;
                    cnt_d   = reload_i;
                end else begin
                    state_d = ST_RUN;
                    if (tick_i) cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = ST_OFF;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_OFF;
            cnt_q   <= PRELOAD;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        active_o   = 1'b0;
        fire_o     = 1'b0;
        rst_req_o  = 1'b0;
        irq_o      = 1'b0;
        ext_trig_o = 1'b0;
        unique case (state_q)
            ST_OFF: ;
            ST_RUN:  active_o = 1'b1;
            ST_FIRE: begin
                active_o   = 1'b1;
                fire_o     = 1'b1;
                rst_req_o  = rst_en_i;
                irq_o      = irq_en_i;
                ext_trig_o = ext_en_i;
            end
            default: ;
        endcase
    end

    assign count_o = cnt_q;

    // R4: disabled and not kicked, the count holds
    p_frozen_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_OFF && !run_en_i && !kick_i) |=> $stable(cnt_q));
    // R5: a timeout only follows a zero count
    p_fire_from_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_FIRE) |-> ($past(cnt_q) == '0));
    // R5: the timeout cycle starts from the reload value
    p_reload_on_fire_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_FIRE) |-> (cnt_q == $past(reload_i)));

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int unsigned ADDR_W   = 5,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned TICK_DIV = 125
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req,
    output logic [1:0]        rst_scope,
    output logic              irq,
    output logic              ext_trig,
    output logic              alt_boot
);
    localparam logic [DATA_W-1:0] KEY  = DATA_W'(KICK_KEY);
    localparam int unsigned       CW   = $bits(ctrl_t);

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] reload_q;
    logic [1:0]        stat_q;
    logic [DATA_W-1:0] count;
    logic              active, fire, pre_tick, tick;
    logic              wr_en, rd_en, kick_hit, clr_hit;

    assign wr_en    = bus_sel && bus_wr;
    assign rd_en    = bus_sel && !bus_wr;
    assign kick_hit = wr_en && bus_addr == ADDR_W'(OFS_KICK) && bus_wdata == KEY;
    assign clr_hit  = wr_en && bus_addr == ADDR_W'(OFS_CLR) && bus_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            reload_q <= '0;
            stat_q   <= '0;
        end else begin
            if (wr_en && bus_addr == ADDR_W'(OFS_CTRL))
                ctrl_q <= ctrl_t'(bus_wdata[CW-1:0]);
            if (wr_en && bus_addr == ADDR_W'(OFS_RELOAD))
                reload_q <= bus_wdata;
            if (fire)
                stat_q <= {stat_q[1] | ctrl_q.alt_boot, 1'b1};
            else if (clr_hit)
                stat_q <= '0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (bus_addr)
                ADDR_W'(OFS_COUNT):  bus_rdata = count;
                ADDR_W'(OFS_RELOAD): bus_rdata = reload_q;
                ADDR_W'(OFS_CTRL):   bus_rdata = DATA_W'(ctrl_q);
                ADDR_W'(OFS_STAT):   bus_rdata = DATA_W'(stat_q);
                default:             bus_rdata = '0;
            endcase
        end
    end

    wdog_prescale #(.DIV(TICK_DIV)) u_pre (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .run_i  (active),
        .tick_o (pre_tick)
    );

    assign tick = ctrl_q.slow_tick ? pre_tick : 1'b1;

    wdog_count #(.CNT_W(DATA_W)) u_cnt (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .run_en_i   (ctrl_q.run_en),
        .rst_en_i   (ctrl_q.rst_en),
        .irq_en_i   (ctrl_q.irq_en),
        .ext_en_i   (ctrl_q.ext_en),
        .tick_i     (tick),
        .kick_i     (kick_hit),
        .reload_i   (reload_q),
        .count_o    (count),
        .active_o   (active),
        .fire_o     (fire),
        .rst_req_o  (rst_req),
        .irq_o      (irq),
        .ext_trig_o (ext_trig)
    );

    assign rst_scope = ctrl_q.scope;
    assign alt_boot  = stat_q[1];

    // R3: a keyed restart loads the reload value
    p_kick_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        kick_hit |=> (count == $past(reload_q)));
    // R7: a reset request needs its enable bit
    p_rst_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ctrl_q.rst_en);
    // R9: alternate-boot flag holds until a clearing write
    p_alt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_boot && !clr_hit) |=> alt_boot);
    // R10: a clearing write with no timeout empties status
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !fire) |=> (stat_q == 2'b00));

endmodule

// File: tb/wdog_timer_test.sv
module wdog_timer_test;
    localparam int unsigned DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req, irq, ext_trig, alt_boot;
    logic [1:0]  rst_scope;

    int unsigned cyc = 0;
    int unsigned n_chk = 0;
    int unsigned n_err = 0;
    int unsigned last_w = 0;
    bit          done = 1'b0;

    typedef struct {
        int unsigned cyc;
        logic        rst;
        logic        irq;
        logic        ext;
        logic [1:0]  scope;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdog_timer #(.TICK_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_req(rst_req), .rst_scope(rst_scope), .irq(irq),
        .ext_trig(ext_trig), .alt_boot(alt_boot)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        last_w = cyc;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_until(input int unsigned c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic push(input int unsigned c, input logic r, input logic i,
                        input logic e, input logic [1:0] s);
        exp_t x;
        x.cyc = c; x.rst = r; x.irq = i; x.ext = e; x.scope = s;
        q.push_back(x);
    endtask

    // monitor: every pulse cycle is matched against the scoreboard
    always @(negedge clk) begin
        if (rst_n && (rst_req || irq || ext_trig)) begin
            if (q.size() == 0) begin
                chk(1'b0, "R7", "unexpected timeout pulse at cycle", cyc, 0);
            end else begin
                exp_t x;
                x = q.pop_front();
                chk(cyc == x.cyc, "R5/R6", "timeout cycle", cyc, x.cyc);
                chk(rst_req == x.rst, "R7", "rst_req", rst_req, x.rst);
                chk(irq == x.irq, "R7", "irq", irq, x.irq);
                chk(ext_trig == x.ext, "R7", "ext_trig", ext_trig, x.ext);
                if (x.rst)
                    chk(rst_scope == x.scope, "R8", "rst_scope", rst_scope, x.scope);
            end
        end
    end

    task automatic drain(input string tag);
        chk(q.size() == 0, "R7", {"missing timeouts after ", tag}, q.size(), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: run hung at cycle %0d", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        int unsigned w, x;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(5'h00, v); chk(v == 32'h00FF_FFFF, "R1", "count after reset", v, 32'h00FF_FFFF);
        rd(5'h04, v); chk(v == 0, "R1", "reload after reset", v, 0);
        rd(5'h0C, v); chk(v == 0, "R1", "control after reset", v, 0);
        rd(5'h10, v); chk(v == 0, "R1", "status after reset", v, 0);
        chk({rst_req, irq, ext_trig, alt_boot} == 0, "R1", "outputs after reset",
            {rst_req, irq, ext_trig, alt_boot}, 0);
        rd(5'h00, v2); chk(v2 == 32'h00FF_FFFF, "R4", "count frozen while disabled", v2, 32'h00FF_FFFF);

        // R2 register map
        wr(5'h04, 32'hDEAD_0005);
        rd(5'h04, v); chk(v == 32'hDEAD_0005, "R2", "reload readback", v, 32'hDEAD_0005);
        wr(5'h0C, 32'hFFFF_FF60);
        rd(5'h0C, v); chk(v == 32'h60, "R2", "control readback", v, 32'h60);
        rd(5'h08, v); chk(v == 0, "R2", "restart register reads 0", v, 0);
        rd(5'h14, v); chk(v == 0, "R2", "clear register reads 0", v, 0);
        wr(5'h0C, 32'h0);

        // R3 key check while disabled, seen through the count
        rd(5'h00, v);
        wr(5'h08, 32'h0000_4754);
        rd(5'h00, v2); chk(v2 == v, "R3", "wrong key leaves count", v2, v);
        wr(5'h08, 32'h0001_4755);
        rd(5'h00, v2); chk(v2 == v, "R3", "key with high bits leaves count", v2, v);
        wr(5'h08, 32'h0000_4755);
        rd(5'h00, v2); chk(v2 == 32'hDEAD_0005, "R3", "magic key loads reload", v2, 32'hDEAD_0005);

        // R5/R7/R8 fast mode, all outputs, full-chip scope
        wr(5'h04, 32'd5);
        wr(5'h0C, 32'h2F);
        w = last_w;
        push(w + 7, 1, 1, 1, 2'd1);
        push(w + 13, 1, 1, 1, 2'd1);
        wait_until(w + 14);
        wr(5'h0C, 32'h0);
        repeat (10) @(negedge clk);
        drain("fast mode");
        rd(5'h00, v); rd(5'h00, v2);
        chk(v == v2, "R4", "count frozen after disable", v2, v);

        // R9 status bit 0 only, then R10 clear
        rd(5'h10, v); chk(v == 32'h1, "R9", "status after plain timeout", v, 1);
        chk(alt_boot == 1'b0, "R9", "alt_boot without bit 7", alt_boot, 0);
        wr(5'h14, 32'h1);
        rd(5'h10, v); chk(v == 0, "R10", "status cleared", v, 0);

        // R3/R7 running: wrong key ignored, magic key shifts schedule; no reset request
        wr(5'h0C, 32'h45);
        w = last_w;
        push(w + 7, 0, 1, 0, 2'd2);
        push(w + 13, 0, 1, 0, 2'd2);
        wait_until(w + 7);
        wr(5'h08, 32'h0000_1234);
        wait_until(w + 13);
        wr(5'h08, 32'h0000_4755);
        x = last_w;
        push(x + 6, 0, 1, 0, 2'd2);
        wait_until(x + 6);
        wr(5'h0C, 32'h0);
        repeat (10) @(negedge clk);
        drain("key test");
        chk(rst_scope == 2'd0, "R8", "scope follows control", rst_scope, 0);

        // R6 slow tick mode
        wr(5'h14, 32'h1);
        wr(5'h04, 32'd2);
        wr(5'h0C, 32'h1D);
        w = last_w;
        push(w + 13, 0, 1, 1, 2'd0);
        push(w + 25, 0, 1, 1, 2'd0);
        wait_until(w + 26);
        wr(5'h0C, 32'h0);
        repeat (20) @(negedge clk);
        drain("slow mode");

        // R9/R10 alternate boot flag
        wr(5'h04, 32'd3);
        wr(5'h0C, 32'h85);
        w = last_w;
        push(w + 5, 0, 1, 0, 2'd0);
        wait_until(w + 5);
        wr(5'h0C, 32'h0);
        repeat (5) @(negedge clk);
        drain("alt boot");
        rd(5'h10, v); chk(v == 32'h3, "R9", "status with alt boot", v, 3);
        chk(alt_boot == 1'b1, "R9", "alt_boot set", alt_boot, 1);
        wr(5'h14, 32'h2);
        rd(5'h10, v); chk(v == 32'h3, "R10", "clear without bit 0 ignored", v, 3);
        chk(alt_boot == 1'b1, "R10", "alt_boot kept", alt_boot, 1);
        wr(5'h14, 32'h1);
        rd(5'h10, v); chk(v == 0, "R10", "status cleared", v, 0);
        chk(alt_boot == 1'b0, "R10", "alt_boot cleared", alt_boot, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule